// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block produces the driver-enable level for a half-duplex RS-485 transceiver from the state of a UART transmit path. Writing a byte into the transmit FIFO turns the line driver on. The driver stays on while bytes are queued or being shifted out. When the transmitter reports the end of a stop bit and the FIFO is empty, a programmable turnaround hold starts. The hold is counted in baud ticks. When it ends, the driver is released so the far end can answer.

The block sits next to the transmit shifter and the baud generator and takes its status from them: a FIFO write strobe, a FIFO-empty flag, a one-cycle end-of-stop-bit pulse and a one-cycle baud tick. The configuration arrives on plain inputs: an enable, a polarity select and an 8-bit hold length. By default the asserted level is low and the released level is high. The polarity select swaps the two levels.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, `dir_out` is 1. The controller starts in the released state.
- R2: While `cfg_en` is 0, `dir_out` shows the released level, which is `~cfg_inv`, one cycle later. FIFO writes and transmitter pulses are ignored.
- R3: With `cfg_en` high, a cycle with `fifo_wr` high drives `dir_out` to the asserted level (`cfg_inv`) in the next cycle.
- R4: While the FIFO is not empty (`fifo_empty` = 0), the output stays asserted. An end-of-stop-bit pulse at such a time does not start the hold, and baud ticks do not release the output.
- R5: An end-of-stop-bit pulse with `fifo_empty` = 1, no write and a nonzero `cfg_delay` = D starts a hold. The output is released in the cycle after the D-th later baud tick is sampled.
- R6: With `cfg_delay` = 0, the output is released in the cycle after the end-of-stop-bit pulse that completes the transfer.
- R7: A FIFO write during the hold cancels it and keeps the output asserted. Release then needs a new end-of-stop-bit pulse and a full new hold.
- R8: The hold length is captured when the hold starts. Changing `cfg_delay` during a hold affects only later holds.
- R9: `cfg_inv` = 1 makes the asserted level 1 and the released level 0. `cfg_inv` = 0 makes the asserted level 0 and the released level 1.
- R10: Clearing `cfg_en` while the output is asserted releases it in the next cycle and discards any hold in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables automatic direction control |
| cfg_inv | input | 1 | Polarity select: 1 makes the asserted level high |
| cfg_delay | input | DLY_W | Turnaround hold in baud ticks (0 to 255 by default) |
| fifo_wr | input | 1 | Transmit FIFO write strobe |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_stop_done | input | 1 | One-cycle pulse when a stop bit has finished on the line |
| baud_tick | input | 1 | One-cycle baud rate tick |
| dir_out | output | 1 | Registered transceiver direction level |

## Verification
The assertions check on every cycle the short relations between the ports:
- a write turns the output on in the next cycle;
- a disabled controller shows the released level;
- a pending FIFO keeps an asserted output asserted;
- a zero-length hold releases at once;
- the hold counter never rises without a reload.

The exact release cycle after D baud ticks can only be shown by the bench scenarios, because D is a runtime value. The same holds for a write that cancels a running hold and for a mid-hold change of the delay value. The bench covers these with directed sequences and with a random run compared against a reference model.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_turn_timer.sv
// Turnaround hold counter: loaded with the captured delay, counts down on baud ticks.
module rs485_turn_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             tick,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign done = tick && (cnt_q == ONE);
  assign cnt  = cnt_q;
endmodule

// File: rtl/rs485_dir_seq.sv
// Direction sequencer: idle, sending, turnaround hold.
module rs485_dir_seq
  import rs485_dir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr,
  input  logic empty,
  input  logic stop_done,
  input  logic dly_zero,
  input  logic timer_done,
  output logic timer_load,
  output logic timer_clear,
  output logic active_nxt
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    timer_load  = 1'b0;
    timer_clear = 1'b0;
    if (!en) begin
      state_d     = ST_IDLE;
      timer_clear = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr) state_d = ST_SEND;
        end
        ST_SEND, ST_HOLD: begin
          if (wr || !empty) begin
            // queued data cancels any running hold
            state_d     = ST_SEND;
            timer_clear = 1'b1;
          end else if (stop_done) begin
            if (dly_zero) begin
              state_d     = ST_IDLE;
              timer_clear = 1'b1;
            end else begin
              state_d    = ST_HOLD;
              timer_load = 1'b1;
            end
          end else if (state_q == ST_HOLD && timer_done) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign active_nxt = (state_d != ST_IDLE);
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_inv,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             fifo_wr,
  input  logic             fifo_empty,
  input  logic             tx_stop_done,
  input  logic             baud_tick,
  output logic             dir_out
);
  logic             t_load;
  logic             t_clear;
  logic             t_done;
  logic             active_nxt;
  logic [DLY_W-1:0] hold_cnt;

  rs485_dir_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_en),
    .wr         (fifo_wr),
    .empty      (fifo_empty),
    .stop_done  (tx_stop_done),
    .dly_zero   (cfg_delay == '0),
    .timer_done (t_done),
    .timer_load (t_load),
    .timer_clear(t_clear),
    .active_nxt (active_nxt)
  );

  rs485_turn_timer #(.CNT_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(cfg_delay),
    .clear   (t_clear),
    .tick    (baud_tick),
    .done    (t_done),
    .cnt     (hold_cnt)
  );

  // asserted level equals cfg_inv, released level is its complement
  always_ff @(posedge clk) begin
    if (rst) dir_out <= 1'b1;
    else     dir_out <= active_nxt ? cfg_inv : ~cfg_inv;
  end
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_inv,
  input logic [DLY_W-1:0] cfg_delay,
  input logic             fifo_wr,
  input logic             fifo_empty,
  input logic             tx_stop_done,
  input logic             dir_out,
  input logic [DLY_W-1:0] hold_cnt
);
  a_r3_write_asserts: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && fifo_wr) |=> (dir_out == $past(cfg_inv)));

  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en) |=> (dir_out == !$past(cfg_inv)));

  a_r6_zero_release: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && tx_stop_done && fifo_empty && !fifo_wr && cfg_delay == '0)
      |=> (dir_out == !$past(cfg_inv)));

  a_r4_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !fifo_empty && !$past(rst) && dir_out == $past(cfg_inv))
      |=> (dir_out == $past(cfg_inv)));

  a_r8_cnt_no_rise: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && fifo_empty && !fifo_wr && !tx_stop_done && hold_cnt != '0)
      |=> (hold_cnt <= $past(hold_cnt)));
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_en      (cfg_en),
  .cfg_inv     (cfg_inv),
  .cfg_delay   (cfg_delay),
  .fifo_wr     (fifo_wr),
  .fifo_empty  (fifo_empty),
  .tx_stop_done(tx_stop_done),
  .dir_out     (dir_out),
  .hold_cnt    (hold_cnt)
);

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;
  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_en = 1'b0;
  logic             cfg_inv = 1'b0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic             fifo_wr = 1'b0;
  logic             fifo_empty = 1'b1;
  logic             tx_stop_done = 1'b0;
  logic             baud_tick = 1'b0;
  logic             dir_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  // reference model state
  bit             m_act;
  bit             m_hold;
  int             m_cnt;
  bit             m_dir;

  always #2.5 clk = ~clk;

  rs485_dir_ctrl #(.DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_inv(cfg_inv),
    .cfg_delay(cfg_delay), .fifo_wr(fifo_wr), .fifo_empty(fifo_empty),
    .tx_stop_done(tx_stop_done), .baud_tick(baud_tick), .dir_out(dir_out)
  );

  function automatic bit level(input bit act, input bit inv);
    return act ? inv : !inv;
  endfunction

  task automatic check(input bit actual, input bit expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: dir_out=%0b expected %0b at cycle %0d", tag, actual, expected, cycles);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_act = 0; m_hold = 0; m_cnt = 0; m_dir = 1;
      return;
    end
    if (!cfg_en) begin
      m_act = 0; m_hold = 0;
    end else if (!m_act) begin
      if (fifo_wr) m_act = 1;
    end else if (fifo_wr || !fifo_empty) begin
      m_hold = 0;
    end else if (tx_stop_done) begin
      if (cfg_delay == 0) begin m_act = 0; m_hold = 0; end
      else begin m_hold = 1; m_cnt = int'(cfg_delay); end
    end else if (m_hold && baud_tick) begin
      if (m_cnt == 1) begin m_act = 0; m_hold = 0; end
      else m_cnt--;
    end
    m_dir = level(m_act, cfg_inv);
  endtask

  // one clock: model follows the inputs held across the edge, compare at negedge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    check(dir_out, m_dir, tag);
  endtask

  task automatic pulse_stop(input string tag);
    tx_stop_done = 1'b1; cyc(tag); tx_stop_done = 1'b0;
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: dir_out=%0b expected run end", dir_out);
    summary();
  end

  initial begin
    // R1 reset
    rst = 1'b1;
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    check(dir_out, 1'b1, "R1");
    cyc("R1");
    check(dir_out, 1'b1, "R1");

    // R2 disabled: writes ignored, released level follows cfg_inv
    cfg_en = 0; fifo_empty = 0; fifo_wr = 1; cyc("R2");
    fifo_wr = 0; pulse_stop("R2"); cyc("R2");
    check(dir_out, 1'b1, "R2");
    cfg_inv = 1; cyc("R2");
    check(dir_out, 1'b0, "R2");
    cfg_inv = 0; fifo_empty = 1; cyc("R2");

    // R3 write asserts in next cycle
    cfg_en = 1; cfg_delay = 3; fifo_wr = 1; cyc("R3");
    check(dir_out, 1'b0, "R3");
    fifo_wr = 0; fifo_empty = 0; repeat (3) cyc("R3");

    // R4 stop bit with data still queued: no hold
    pulse_stop("R4");
    for (int i = 0; i < 6; i++) begin baud_tick = 1; cyc("R4"); baud_tick = 0; end
    check(dir_out, 1'b0, "R4");

    // R5 release after exactly 3 ticks
    fifo_empty = 1; pulse_stop("R5");
    for (int i = 0; i < 3; i++) begin
      cyc("R5"); cyc("R5");
      check(dir_out, 1'b0, "R5");
      baud_tick = 1; cyc("R5"); baud_tick = 0;
      check(dir_out, (i == 2) ? 1'b1 : 1'b0, "R5");
    end

    // R6 zero delay releases the cycle after the stop bit
    cfg_delay = 0; fifo_wr = 1; cyc("R6"); fifo_wr = 0; cyc("R6");
    pulse_stop("R6");
    check(dir_out, 1'b1, "R6");

    // R7 write during hold cancels it
    cfg_delay = 2; fifo_wr = 1; cyc("R7"); fifo_wr = 0;
    pulse_stop("R7");
    baud_tick = 1; cyc("R7"); baud_tick = 0;
    fifo_wr = 1; cyc("R7"); fifo_wr = 0;
    baud_tick = 1; repeat (4) cyc("R7"); baud_tick = 0;
    check(dir_out, 1'b0, "R7");
    pulse_stop("R7");
    baud_tick = 1; cyc("R7");
    check(dir_out, 1'b0, "R7");
    cyc("R7"); baud_tick = 0;
    check(dir_out, 1'b1, "R7");

    // R8 delay change during hold has no effect on that hold
    cfg_delay = 4; fifo_wr = 1; cyc("R8"); fifo_wr = 0;
    pulse_stop("R8");
    cfg_delay = 1;
    baud_tick = 1; repeat (3) cyc("R8");
    check(dir_out, 1'b0, "R8");
    cyc("R8"); baud_tick = 0;
    check(dir_out, 1'b1, "R8");

    // R9 inverted polarity
    cfg_inv = 1; cyc("R9");
    check(dir_out, 1'b0, "R9");
    fifo_wr = 1; cyc("R9"); fifo_wr = 0;
    check(dir_out, 1'b1, "R9");
    pulse_stop("R9");
    baud_tick = 1; cyc("R9"); baud_tick = 0;
    check(dir_out, 1'b0, "R9");
    cfg_inv = 0; cyc("R9");

    // R10 disable mid-transfer
    cfg_delay = 5; fifo_wr = 1; cyc("R10"); fifo_wr = 0;
    pulse_stop("R10");
    cfg_en = 0; cyc("R10");
    check(dir_out, 1'b1, "R10");
    cfg_en = 1; baud_tick = 1; repeat (6) cyc("R10"); baud_tick = 0;
    check(dir_out, 1'b1, "R10");

    // random traffic against the model (R3 R4 R5 R7 R8 R9)
    void'($urandom(32'd12345));
    for (int n = 0; n < 4000; n++) begin
      cfg_en       = ($urandom_range(99) < 97);
      if ($urandom_range(99) < 2) cfg_inv = ~cfg_inv;
      if ($urandom_range(99) < 5)
        cfg_delay = ($urandom_range(9) == 0) ? 8'd255 : DLY_W'($urandom_range(6));
      fifo_wr      = ($urandom_range(99) < 8);
      fifo_empty   = ($urandom_range(99) < 70);
      tx_stop_done = ($urandom_range(99) < 12);
      baud_tick    = ($urandom_range(99) < 30);
      cyc("R5 random");
    end
    fifo_wr = 0; tx_stop_done = 0; baud_tick = 0;
    summary();
  end
endmodule